// File: doc/BRIEF.md
# FPU Status and Exception Control Register

This block is the status and control register that sits beside a floating-point datapath. It holds a two-bit rounding-mode field, a flush-to-zero bit, and three five-bit exception groups: cause, sticky flags and trap enables. Software reads the whole register on `csr_q` and changes it through a write port that takes a per-bit mask. A fixed mask decides which bits can be stored at all.

When the datapath finishes an operation it pulses `op_done` and presents its five raw exception indications. The cause group is rebuilt from those indications on every completion. The flag group keeps every cause bit ever seen. If a new cause bit matches a set enable bit, the block issues a one-cycle trap request with a fixed vector code. Approximate reciprocal-square-root operations are tagged with `op_approx`. When such an operation reports no exception, the block records it as inexact.

The rounding field drives `round_to_zero`, and the denormal bit drives `flush_denorm`. The datapath uses both.

Top module: `fpu_status_ctrl`

## Requirements

Bit positions in the register:
- rounding mode: [1:0]
- flags: [6:2]
- enables: [11:7]
- cause: [16:12]
- denormal flush: [18]

Inside each five-bit group the bit order is the same: bit 0 inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero, bit 4 invalid. The fixed write mask is 0x0005FFFF. Bits 17 and 19 to 31 always read zero.

- R1: A synchronous active-high reset clears the whole register to 0, so the rounding mode is nearest and every cause, flag and enable bit is cleared. The reset also clears `trap_req` and `trap_vec`.
- R2: A write with no operation completion in the same cycle replaces exactly the bits set in both `wr_mask` and the fixed mask 0x0005FFFF. All other bits keep their value, and the bits outside the fixed mask stay zero.
- R3: On each `op_done`, the cause field [16:12] takes the raw exception bits. Bits that were set before and are not reported now are cleared.
- R4: On each `op_done`, the flag field [6:2] becomes its old value ORed with the new cause bits. Flag bits are never cleared by an operation.
- R5: An operation completion leaves the rounding, enable and denormal fields unchanged.
- R6: `trap_req` is high for exactly the one cycle after an `op_done` whose new cause ANDed with the enable field is non-zero. It is low otherwise.
- R7: `trap_vec` reads 0x120 while `trap_req` is high and 0 otherwise.
- R8: `round_to_zero` is high exactly when the rounding field holds 2'b01. Every other value selects round-to-nearest-even, and `round_to_zero` is low.
- R9: `flush_denorm` follows bit 18.
- R10: On an `op_done` with `op_approx` high and all raw bits zero, the new cause is 5'b00001 (inexact). If any raw bit is set, the raw bits are used unchanged.
- R11: When a write and `op_done` fall in the same cycle, the operation update is applied and the write is discarded.
- R12: With neither a write nor `op_done`, the register keeps its value.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write data |
| wr_mask | input | 32 | Per-bit write enable |
| op_done | input | 1 | Operation-complete strobe from the datapath |
| exc_raw | input | 5 | Raw exception indications of the completing operation |
| op_approx | input | 1 | Completing operation is an approximate reciprocal square root |
| csr_q | output | 32 | Current register value |
| round_to_zero | output | 1 | Truncating rounding selected |
| flush_denorm | output | 1 | Flush denormals to zero |
| trap_req | output | 1 | One-cycle trap request |
| trap_vec | output | 12 | Trap vector code, 0x120 while requesting |

## Verification

Every state bit is visible on `csr_q` one cycle after the edge that changes it. A wrong cause rebuild, a lost sticky flag or a stray write therefore shows up at the port on the very next sample.

Enable and cause faults also show one cycle later, as a missing or spurious `trap_req` pulse. A mis-decoded rounding or denormal field shows up at once on `round_to_zero` or `flush_denorm` when the register is read.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;

  localparam int NEXC = 5;

  // bit order within each exception group
  localparam int EX_INEXACT  = 0;
  localparam int EX_UNDERFLOW = 1;
  localparam int EX_OVERFLOW = 2;
  localparam int EX_DIVZERO  = 3;
  localparam int EX_INVALID  = 4;

  typedef logic [NEXC-1:0] exc_vec_t;

  // cause for a completed operation; approximations report inexact when clean
  function automatic exc_vec_t shape_cause(exc_vec_t raw, logic approx);
    exc_vec_t res;
    res = raw;
    if (approx && (raw == '0)) begin
      res = '0;
      res[EX_INEXACT] = 1'b1;
    end
    return res;
  endfunction

  function automatic logic trap_hit(exc_vec_t cause, exc_vec_t enable);
    return |(cause & enable);
  endfunction

  function automatic logic rm_truncates(logic [1:0] rm, logic [1:0] rtz_code);
    return rm == rtz_code;
  endfunction

endpackage

// File: rtl/fpsc_cause_gen.sv
module fpsc_cause_gen
  import fpsc_pkg::*;
(
  input  exc_vec_t raw,
  input  logic     approx,
  output exc_vec_t cause_new
);

  assign cause_new = shape_cause(raw, approx);

  always_comb begin
    if (raw != '0) begin
      a_raw_passthru_r10 : assert (cause_new == raw);
    end
  end

endmodule

// File: rtl/fpsc_regfile.sv
module fpsc_regfile
  import fpsc_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          FLAG_LSB  = 2,
  parameter int          CAUSE_LSB = 12,
  parameter logic [31:0] FIX_MASK  = 32'h0005_FFFF,
  parameter logic [31:0] RST_VAL   = 32'h0
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] wr_mask,
  input  logic              upd,
  input  exc_vec_t          cause_new,
  output logic [DATA_W-1:0] reg_q,
  output logic              wr_take
);

  localparam logic [DATA_W-1:0] FIXM = FIX_MASK[DATA_W-1:0];
  localparam logic [DATA_W-1:0] RSTV = RST_VAL[DATA_W-1:0];

  logic [DATA_W-1:0] eff_mask;
  logic [DATA_W-1:0] wr_next;
  logic [DATA_W-1:0] upd_next;
  logic [DATA_W-1:0] reg_d;
  exc_vec_t          sticky_next;

  assign wr_take  = wr_en & ~upd;
  assign eff_mask = wr_mask & FIXM;
  assign wr_next  = (reg_q & ~eff_mask) | (wr_data & eff_mask);

  // per-exception sticky accumulation
  for (genvar i = 0; i < NEXC; i++) begin : g_sticky
    assign sticky_next[i] = reg_q[FLAG_LSB+i] | cause_new[i];
  end

  always_comb begin
    upd_next = reg_q;
    upd_next[CAUSE_LSB +: NEXC] = cause_new;
    upd_next[FLAG_LSB  +: NEXC] = sticky_next;
  end

  always_comb begin
    if (upd)          reg_d = upd_next;
    else if (wr_take) reg_d = wr_next;
    else              reg_d = reg_q;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_q <= RSTV;
    else     reg_q <= reg_d;
  end

  p_write_masked_r2 : assert property (@(posedge clk) disable iff (rst)
    wr_take |=> ((reg_q ^ $past(reg_q)) & ~$past(eff_mask)) == '0);

  p_reserved_zero_r2 : assert property (@(posedge clk) disable iff (rst)
    (reg_q & ~FIXM) == '0);

  p_upd_wins_r11 : assert property (@(posedge clk) disable iff (rst)
    (upd && wr_en) |=> reg_q[1:0] == $past(reg_q[1:0]));

  p_idle_stable_r12 : assert property (@(posedge clk) disable iff (rst)
    (!upd && !wr_en) |=> reg_q == $past(reg_q));

endmodule

// File: rtl/fpsc_trap_gen.sv
module fpsc_trap_gen
  import fpsc_pkg::*;
#(
  parameter int          VEC_W    = 12,
  parameter logic [11:0] TRAP_VEC = 12'h120
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  exc_vec_t         cause_new,
  input  exc_vec_t         enable,
  output logic             trap_req,
  output logic [VEC_W-1:0] trap_vec
);

  localparam logic [VEC_W-1:0] VEC = VEC_W'(TRAP_VEC);

  logic fire;

  assign fire = upd & trap_hit(cause_new, enable);

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_req <= 1'b0;
      trap_vec <= '0;
    end else begin
      trap_req <= fire;
      trap_vec <= fire ? VEC : '0;
    end
  end

  p_no_trap_idle_r6 : assert property (@(posedge clk) disable iff (rst)
    !upd |=> !trap_req);

  p_vec_code_r7 : assert property (@(posedge clk) disable iff (rst)
    trap_req |-> trap_vec == VEC);

  p_vec_quiet_r7 : assert property (@(posedge clk) disable iff (rst)
    !trap_req |-> trap_vec == '0);

endmodule

// File: rtl/fpu_status_ctrl.sv
module fpu_status_ctrl
  import fpsc_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          RM_LSB    = 0,
  parameter int          FLAG_LSB  = 2,
  parameter int          EN_LSB    = 7,
  parameter int          CAUSE_LSB = 12,
  parameter int          DN_BIT    = 18,
  parameter logic [31:0] FIX_MASK  = 32'h0005_FFFF,
  parameter logic [31:0] RST_VAL   = 32'h0,
  parameter logic [1:0]  RTZ_CODE  = 2'b01,
  parameter int          VEC_W     = 12,
  parameter logic [11:0] TRAP_VEC  = 12'h120
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] wr_mask,
  input  logic              op_done,
  input  logic [4:0]        exc_raw,
  input  logic              op_approx,
  output logic [DATA_W-1:0] csr_q,
  output logic              round_to_zero,
  output logic              flush_denorm,
  output logic              trap_req,
  output logic [VEC_W-1:0]  trap_vec
);

  exc_vec_t   cause_new;
  exc_vec_t   en_field;
  exc_vec_t   cause_field;
  exc_vec_t   flag_field;
  logic [1:0] rm_field;
  logic       wr_take;

  fpsc_cause_gen u_cause (
    .raw       (exc_raw),
    .approx    (op_approx),
    .cause_new (cause_new)
  );

  fpsc_regfile #(
    .DATA_W    (DATA_W),
    .FLAG_LSB  (FLAG_LSB),
    .CAUSE_LSB (CAUSE_LSB),
    .FIX_MASK  (FIX_MASK),
    .RST_VAL   (RST_VAL)
  ) u_reg (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .wr_mask   (wr_mask),
    .upd       (op_done),
    .cause_new (cause_new),
    .reg_q     (csr_q),
    .wr_take   (wr_take)
  );

  assign en_field    = csr_q[EN_LSB    +: NEXC];
  assign cause_field = csr_q[CAUSE_LSB +: NEXC];
  assign flag_field  = csr_q[FLAG_LSB  +: NEXC];
  assign rm_field    = csr_q[RM_LSB    +: 2];

  fpsc_trap_gen #(
    .VEC_W    (VEC_W),
    .TRAP_VEC (TRAP_VEC)
  ) u_trap (
    .clk       (clk),
    .rst       (rst),
    .upd       (op_done),
    .cause_new (cause_new),
    .enable    (en_field),
    .trap_req  (trap_req),
    .trap_vec  (trap_vec)
  );

  assign round_to_zero = rm_truncates(rm_field, RTZ_CODE);
  assign flush_denorm  = csr_q[DN_BIT];

  p_reset_r1 : assert property (@(posedge clk)
    rst |=> (csr_q == RST_VAL[DATA_W-1:0]) && !trap_req);

  p_cause_load_r3 : assert property (@(posedge clk) disable iff (rst)
    (op_done && !op_approx) |=> cause_field == $past(exc_raw));

  p_flag_sticky_r4 : assert property (@(posedge clk) disable iff (rst)
    op_done |=> flag_field == ($past(flag_field) | cause_field));

  p_ctrl_kept_r5 : assert property (@(posedge clk) disable iff (rst)
    op_done |=> (en_field == $past(en_field)) && (rm_field == $past(rm_field))
                && (flush_denorm == $past(flush_denorm)));

  p_trap_match_r6 : assert property (@(posedge clk) disable iff (rst)
    op_done |=> trap_req == |(cause_field & en_field));

  p_approx_inexact_r10 : assert property (@(posedge clk) disable iff (rst)
    (op_done && op_approx && exc_raw == '0) |=> cause_field == 5'b00001);

  p_write_dropped_r11 : assert property (@(posedge clk) disable iff (rst)
    (op_done && wr_en) |=> !$past(wr_take));

endmodule

// File: tb/sim_fpu_status_ctrl.sv
module sim_fpu_status_ctrl;

  typedef struct {
    logic [31:0] csr;
    logic        trap;
    logic [11:0] vec;
    logic        rtz;
    logic        ftz;
    string       tag;
  } exp_t;

  localparam logic [31:0] FIXM = 32'h0005_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] wr_mask = '0;
  logic        op_done = 1'b0;
  logic [4:0]  exc_raw = '0;
  logic        op_approx = 1'b0;
  logic [31:0] csr_q;
  logic        round_to_zero, flush_denorm, trap_req;
  logic [11:0] trap_vec;

  int total = 0;
  int bad = 0;
  exp_t sb[$];
  logic [31:0] m_reg = '0;
  logic        m_trap = 1'b0;
  bit          finished = 0;

  always #2.5 clk = ~clk;

  fpu_status_ctrl u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_mask(wr_mask),
    .op_done(op_done), .exc_raw(exc_raw), .op_approx(op_approx),
    .csr_q(csr_q), .round_to_zero(round_to_zero), .flush_denorm(flush_denorm),
    .trap_req(trap_req), .trap_vec(trap_vec)
  );

  task automatic chk32(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and queue the expected result
  task automatic step(logic we, logic [31:0] wd, logic [31:0] wm,
                      logic od, logic [4:0] raw, logic ap, string tag);
    logic [4:0]  nc;
    logic [31:0] eff;
    exp_t e;
    @(negedge clk);
    wr_en = we; wr_data = wd; wr_mask = wm;
    op_done = od; exc_raw = raw; op_approx = ap;
    if (od) begin
      nc = (ap && raw == 5'd0) ? 5'b00001 : raw;
      m_trap = (nc & m_reg[11:7]) != 5'd0;
      m_reg[16:12] = nc;
      m_reg[6:2] = m_reg[6:2] | nc;
    end else begin
      m_trap = 1'b0;
      if (we) begin
        eff = wm & FIXM;
        m_reg = (m_reg & ~eff) | (wd & eff);
      end
    end
    e.csr = m_reg; e.trap = m_trap; e.vec = m_trap ? 12'h120 : 12'h000;
    e.rtz = (m_reg[1:0] == 2'b01); e.ftz = m_reg[18]; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(string tag);
    step(1'b0, '0, '0, 1'b0, 5'd0, 1'b0, tag);
  endtask

  // monitor: compare after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk32(e.tag, "csr", csr_q, e.csr);
        chk32(e.tag, "trap_req", {31'd0, trap_req}, {31'd0, e.trap});
        chk32(e.tag, "trap_vec", {20'd0, trap_vec}, {20'd0, e.vec});
        chk32(e.tag, "round_to_zero", {31'd0, round_to_zero}, {31'd0, e.rtz});
        chk32(e.tag, "flush_denorm", {31'd0, flush_denorm}, {31'd0, e.ftz});
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk32("R1", "csr", csr_q, 32'h0);
    chk32("R1", "trap_req", {31'd0, trap_req}, 32'd0);
    chk32("R1", "trap_vec", {20'd0, trap_vec}, 32'd0);
    chk32("R1", "round_to_zero", {31'd0, round_to_zero}, 32'd0);

    // R2, R8, R9: full write through fixed mask, rm=11 is nearest
    step(1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 5'd0, 1'b0, "R2_R8_R9");
    // R8: rounding field 01 selects truncation
    step(1'b1, 32'h0000_0001, 32'h0000_0003, 1'b0, 5'd0, 1'b0, "R8");
    // R2: partial per-bit mask
    step(1'b1, 32'h0000_0000, 32'h0000_0F00, 1'b0, 5'd0, 1'b0, "R2");
    // R9: clear denormal bit, keep rest
    step(1'b1, 32'h0000_0000, 32'h0004_0000, 1'b0, 5'd0, 1'b0, "R9");
    // clear everything
    step(1'b1, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 5'd0, 1'b0, "R2");
    // R3, R4, R6: operation with no enables, no trap
    step(1'b0, '0, '0, 1'b1, 5'b10100, 1'b0, "R3_R4_R6");
    // R3 rebuild, R4 sticky
    step(1'b0, '0, '0, 1'b1, 5'b00010, 1'b0, "R3_R4");
    // enable overflow only, set rm and dn too
    step(1'b1, 32'h0004_0201, 32'h0004_0F83, 1'b0, 5'd0, 1'b0, "R2");
    // R6, R7, R5: enabled overflow traps
    step(1'b0, '0, '0, 1'b1, 5'b00100, 1'b0, "R5_R6_R7");
    idle("R6_R12");
    // R6: unmatched cause, no trap
    step(1'b0, '0, '0, 1'b1, 5'b01000, 1'b0, "R6");
    // R10: clean approximation gives inexact
    step(1'b0, '0, '0, 1'b1, 5'b00000, 1'b1, "R10");
    // R10: approximation with overflow keeps raw, traps
    step(1'b0, '0, '0, 1'b1, 5'b00100, 1'b1, "R10_R6");
    // R11: write collides with update, write dropped
    step(1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 5'b00000, 1'b0, "R11_R3");
    // back-to-back traps
    step(1'b0, '0, '0, 1'b1, 5'b00101, 1'b0, "R6");
    step(1'b0, '0, '0, 1'b1, 5'b10100, 1'b0, "R6_R4");
    // R12: idle and write with zero mask
    idle("R12");
    step(1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 5'd0, 1'b0, "R12_R2");
    idle("R12");
    // R1: reset again mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_reg = '0; m_trap = 1'b0;
    chk32("R1", "csr", csr_q, 32'h0);
    chk32("R1", "trap_req", {31'd0, trap_req}, 32'd0);
    idle("R12");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule